// File: doc/BRIEF.md
# Hardware Buffer Descriptor Stack Manager

This block keeps a set of last-in-first-out stacks of free buffer addresses behind a single memory-mapped request port. Software or an agent returns a buffer by storing its virtual address to an address that selects a stack. It obtains a buffer by loading from that address. The load removes the newest entry of the selected stack and returns a 64-bit descriptor word.

The descriptor is assembled when the entry is popped. It carries the buffer address, the stack number, a fixed instance number, a flag marking the buffer as hardware managed, the stack's configured buffer-size code and a status code. An empty stack does not stall the requester: the load returns a failure status. Each stack has a size register that is written through a separate configuration port. A push to a stack that is already full is discarded, and a per-stack sticky flag records the loss.

Top module: `buf_stack_mgr`

## Requirements
- R1: A request is decoded only when `req_addr[28:26]` equals 6. Any other request leaves every stack unchanged and produces no `rd_valid`.
- R2: `req_addr[7:3]` selects the stack. An index at or above NUM_STACKS drops a store. A load to such an index returns the failure descriptor of R6 with size code 0.
- R3: A store pushes `req_wdata[41:7]` onto the selected stack. All other write-data bits, including the index, instance, flag, size and status fields, are ignored.
- R4: A load pops the newest entry of the selected stack, so entries come back in reverse order of their pushes.
- R5: A successful pop returns address in [41:7], stack index in [52:48], INST_ID in [57:56], 1 at bit 58, the stack's size code in [61:59] and status 0 in [63:62]. All other bits are 0.
- R6: A load from an empty stack returns status 3 and zero in [41:7]. The other fields are as in R5, and the stack stays empty.
- R7: A push to a full stack (DEPTH entries) is dropped and sets that stack's bit of `ovf_flags`. The bit stays set until reset.
- R8: `rd_valid` is high for exactly the one cycle after each decoded load, with `rd_data` valid in that cycle.
- R9: When `cfg_we` is high, `cfg_size` is written to the size register of stack `cfg_stack`. Size codes 0 to 7 denote buffers of 128, 256, 512, 1024, 1664, 4096, 10368 and 16384 bytes. A load in the same cycle as a size write reports the old code.
- R10: After reset every stack is empty, every size code is 0, `ovf_flags` is 0 and `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = store (push), 0 = load (pop) |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 64 | Store data |
| cfg_we | input | 1 | Size register write strobe |
| cfg_stack | input | 5 | Stack whose size register is written |
| cfg_size | input | 3 | New size code |
| rd_valid | output | 1 | Load response strobe |
| rd_data | output | 64 | Load response descriptor |
| ovf_flags | output | NUM_STACKS | Sticky per-stack push-overflow flags |

## Verification
A load's descriptor is registered once, so it is due on the clock edge after the request and is gone one edge later. The bench drives each request at a falling edge and samples `rd_valid` and `rd_data` at the next falling edge, which is half a cycle after the edge that produced them. It then checks at the falling edge after that that `rd_valid` has dropped. Pushes, overflow flags and size writes take effect at the edge that accepts the request. The bench observes them through later loads and through `ovf_flags`, sampled at the falling edge after that acceptance edge.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int VA_W     = 35;
  localparam int SIDX_W   = 5;
  localparam int SIZE_W   = 3;
  localparam int DESC_W   = 64;
  localparam logic [2:0] REGION_SEL = 3'd6;
  localparam logic [1:0] ST_OK      = 2'd0;
  localparam logic [1:0] ST_EMPTY   = 2'd3;

  function automatic logic [2:0] addr_region(input logic [28:0] a);
    return a[28:26];
  endfunction

  function automatic logic [SIDX_W-1:0] addr_stack(input logic [28:0] a);
    return a[7:3];
  endfunction

  function automatic logic [VA_W-1:0] wdata_va(input logic [DESC_W-1:0] w);
    return w[41:7];
  endfunction

  function automatic logic [DESC_W-1:0] make_desc(
    input logic              ok,
    input logic [VA_W-1:0]   va,
    input logic [SIDX_W-1:0] idx,
    input logic [1:0]        inst,
    input logic [SIZE_W-1:0] size
  );
    logic [DESC_W-1:0] d;
    d        = '0;
    d[63:62] = ok ? ST_OK : ST_EMPTY;
    d[61:59] = size;
    d[58]    = 1'b1;
    d[57:56] = inst;
    d[52:48] = idx;
    d[41:7]  = ok ? va : '0;
    return d;
  endfunction
endpackage

// File: rtl/bsm_decode.sv
module bsm_decode
  import bsm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_STACKS = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              push_evt,
  output logic              pop_evt,
  output logic [SIDX_W-1:0] sel_idx,
  output logic [NUM_STACKS-1:0] sel_onehot
);
  logic hit;

  assign hit      = req_valid && (addr_region(req_addr[28:0]) == REGION_SEL);
  assign push_evt = hit && req_write;
  assign pop_evt  = hit && !req_write;
  assign sel_idx  = addr_stack(req_addr[28:0]);

  for (genvar i = 0; i < NUM_STACKS; i++) begin : g_sel
    assign sel_onehot[i] = (sel_idx == SIDX_W'(i));
  end
endmodule

// File: rtl/bsm_lifo.sv
module bsm_lifo #(
  parameter int DEPTH = 16,
  parameter int W     = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic         pop_ok,
  output logic [W-1:0] pop_data,
  output logic         drop_evt,
  output logic         ovf
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [LVL_W-1:0] level;
  logic             empty, full;
  logic [PTR_W-1:0] top_ptr, wr_ptr;

  assign empty    = (level == '0);
  assign full     = (level == LVL_W'(DEPTH));
  assign top_ptr  = PTR_W'(level - LVL_W'(1));
  assign wr_ptr   = PTR_W'(level);
  assign pop_ok   = !empty;
  assign pop_data = empty ? '0 : mem[top_ptr];
  assign drop_evt = push && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (push) begin
        if (full) ovf <= 1'b1;
        else level <= level + LVL_W'(1);
      end else if (pop && !empty) begin
        level <= level - LVL_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/bsm_resp.sv
module bsm_resp
  import bsm_pkg::*;
#(
  parameter logic [1:0] INST_ID = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop_evt,
  input  logic              ok,
  input  logic [VA_W-1:0]   va,
  input  logic [SIDX_W-1:0] idx,
  input  logic [SIZE_W-1:0] size,
  output logic              rd_valid,
  output logic [DESC_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= pop_evt;
      if (pop_evt) rd_data <= make_desc(ok, va, idx, INST_ID, size);
    end
  end
endmodule

// File: rtl/buf_stack_mgr.sv
module buf_stack_mgr
  import bsm_pkg::*;
#(
  parameter int         ADDR_W     = 32,
  parameter int         NUM_STACKS = 8,
  parameter int         DEPTH      = 16,
  parameter logic [1:0] INST_ID    = 2'd1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [63:0]           req_wdata,
  input  logic                  cfg_we,
  input  logic [4:0]            cfg_stack,
  input  logic [2:0]            cfg_size,
  output logic                  rd_valid,
  output logic [63:0]           rd_data,
  output logic [NUM_STACKS-1:0] ovf_flags
);
  logic                  push_evt, pop_evt;
  logic [SIDX_W-1:0]     sel_idx;
  logic [NUM_STACKS-1:0] sel_onehot;
  logic [NUM_STACKS-1:0] ok_vec, drop_vec;
  logic [VA_W-1:0]       va_arr   [NUM_STACKS];
  logic [SIZE_W-1:0]     size_arr [NUM_STACKS];
  logic                  sel_ok;
  logic [VA_W-1:0]       sel_va;
  logic [SIZE_W-1:0]     sel_size;
  logic                  drop_evt;

  bsm_decode #(.ADDR_W(ADDR_W), .NUM_STACKS(NUM_STACKS)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .push_evt  (push_evt),
    .pop_evt   (pop_evt),
    .sel_idx   (sel_idx),
    .sel_onehot(sel_onehot)
  );

  for (genvar i = 0; i < NUM_STACKS; i++) begin : g_stk
    bsm_lifo #(.DEPTH(DEPTH), .W(VA_W)) u_lifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push_evt && sel_onehot[i]),
      .pop     (pop_evt && sel_onehot[i]),
      .din     (wdata_va(req_wdata)),
      .pop_ok  (ok_vec[i]),
      .pop_data(va_arr[i]),
      .drop_evt(drop_vec[i]),
      .ovf     (ovf_flags[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) size_arr[i] <= '0;
      else if (cfg_we && cfg_stack == SIDX_W'(i)) size_arr[i] <= cfg_size;
    end
  end

  always_comb begin
    sel_va   = '0;
    sel_size = '0;
    for (int i = 0; i < NUM_STACKS; i++) begin
      if (sel_onehot[i]) begin
        sel_va   = va_arr[i];
        sel_size = size_arr[i];
      end
    end
  end

  assign sel_ok   = |(ok_vec & sel_onehot);
  assign drop_evt = |drop_vec;

  bsm_resp #(.INST_ID(INST_ID)) u_resp (
    .clk     (clk),
    .rst_n   (rst_n),
    .pop_evt (pop_evt),
    .ok      (sel_ok),
    .va      (sel_va),
    .idx     (sel_idx),
    .size    (sel_size),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/buf_stack_mgr_chk.sv
module buf_stack_mgr_chk #(
  parameter int ADDR_W     = 32,
  parameter int NUM_STACKS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     req_addr,
  input logic                  pop_evt,
  input logic                  push_evt,
  input logic                  drop_evt,
  input logic                  rd_valid,
  input logic [63:0]           rd_data,
  input logic [NUM_STACKS-1:0] ovf_flags
);
  // R8: a decoded load is answered on the next edge
  assert_load_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> rd_valid);

  // R8: no response without a load one cycle earlier
  assert_no_spurious_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(pop_evt));

  // R5: hardware flag reads 1
  assert_hwb_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data[58]);

  // R5 / R6: status is either success or empty
  assert_status_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[63:62] == 2'd0 || rd_data[63:62] == 2'd3));

  // R6: failure carries a zero address
  assert_fail_zero_va_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_data[63:62] == 2'd3) |-> (rd_data[41:7] == '0));

  // R2: index field echoes the request address
  assert_index_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[52:48] == $past(req_addr[7:3])));

  // R7: overflow flags never clear
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

  // R7: a dropped push raises a flag
  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (ovf_flags != '0));

  // R1: a push and a pop never decode together
  assert_one_op_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_evt && pop_evt));
endmodule

bind buf_stack_mgr buf_stack_mgr_chk #(.ADDR_W(ADDR_W), .NUM_STACKS(NUM_STACKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_addr (req_addr),
  .pop_evt  (pop_evt),
  .push_evt (push_evt),
  .drop_evt (drop_evt),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .ovf_flags(ovf_flags)
);

// File: tb/buf_stack_mgr_test.sv
`timescale 1ns/1ps
module buf_stack_mgr_test;
  localparam int         NS   = 4;
  localparam int         DP   = 4;
  localparam logic [1:0] INST = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_stack = '0;
  logic [2:0]  cfg_size = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [NS-1:0] ovf_flags;

  int n_tests = 0, n_fail = 0;
  int m_cnt [NS];
  logic [34:0] m_mem [NS][DP];
  logic [2:0]  m_cfg [NS];
  logic [NS-1:0] m_ovf;

  always #10 clk = ~clk;

  buf_stack_mgr #(.ADDR_W(32), .NUM_STACKS(NS), .DEPTH(DP), .INST_ID(INST)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_we(cfg_we),
    .cfg_stack(cfg_stack), .cfg_size(cfg_size), .rd_valid(rd_valid),
    .rd_data(rd_data), .ovf_flags(ovf_flags)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_desc(input bit ok, input logic [34:0] va,
                                           input int idx, input logic [2:0] sz);
    logic [63:0] d;
    d = 64'h1 << 58;
    d = d | (64'(INST) << 56) | (64'(sz) << 59) | (64'(idx & 31) << 48);
    if (ok) d = d | (64'(va) << 7);
    else    d = d | (64'h3 << 62);
    return d;
  endfunction

  function automatic logic [31:0] mk_addr(input logic [2:0] region, input int idx);
    logic [31:0] a;
    a = $urandom;
    a[28:26] = region;
    a[7:3] = 5'(idx);
    return a;
  endfunction

  // one request; optional same-cycle config write
  task automatic do_req(input bit wr, input logic [31:0] a, input logic [63:0] wd,
                        input bit cw, input int cs, input logic [2:0] csz,
                        input string req);
    bit hit; int idx; logic [63:0] exp; bit ok; logic [34:0] va; logic [2:0] sz;
    hit = (a[28:26] == 3'd6);
    idx = int'(a[7:3]);
    ok = 0; va = '0; sz = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    cfg_we = cw; cfg_stack = 5'(cs); cfg_size = csz;
    // model, using state before this edge
    if (hit && !wr) begin
      if (idx < NS) begin
        sz = m_cfg[idx];
        if (m_cnt[idx] > 0) begin
          ok = 1; m_cnt[idx]--; va = m_mem[idx][m_cnt[idx]];
        end
      end
    end
    if (hit && wr && idx < NS) begin
      if (m_cnt[idx] == DP) m_ovf[idx] = 1'b1;
      else begin m_mem[idx][m_cnt[idx]] = wd[41:7]; m_cnt[idx]++; end
    end
    if (cw && cs < NS) m_cfg[cs] = csz;
    exp = exp_desc(ok, va, idx, sz);
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    check64({req, " rd_valid"}, 64'(rd_valid), 64'(hit && !wr));
    if (hit && !wr) check64({req, " descriptor"}, rd_data, exp);
    check64("R7 ovf_flags", 64'(ovf_flags), 64'(m_ovf));
    @(negedge clk);
    check64("R8 rd_valid drops", 64'(rd_valid), 64'd0);
  endtask

  task automatic push(input int idx, input logic [34:0] va, input string req);
    logic [63:0] wd;
    wd = {$urandom, $urandom};
    wd[41:7] = va;
    do_req(1'b1, mk_addr(3'd6, idx), wd, 1'b0, 0, 3'd0, req);
  endtask

  task automatic pop(input int idx, input string req);
    do_req(1'b0, mk_addr(3'd6, idx), 64'd0, 1'b0, 0, 3'd0, req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NS; i++) begin m_cnt[i] = 0; m_cfg[i] = 3'd0; end
    m_ovf = '0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    check64("R10 rd_valid", 64'(rd_valid), 64'd0);
    check64("R10 ovf_flags", 64'(ovf_flags), 64'd0);
    pop(0, "R10 R6 empty after reset");
    // R4 LIFO order, R7 overflow on stack 1
    for (int k = 0; k < DP; k++) push(1, 35'(100 + k), "R3 push");
    push(1, 35'h7_0000_0001, "R7 push to full");
    for (int k = 0; k < DP; k++) pop(1, "R4 R5 lifo pop");
    pop(1, "R6 drained pop");
    // R3 junk write fields ignored
    do_req(1'b1, mk_addr(3'd6, 2), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 0, 3'd0, "R3 junk fields");
    pop(2, "R3 junk fields pop");
    // R1 off-region requests
    push(3, 35'h55, "R1 setup");
    do_req(1'b1, mk_addr(3'd5, 3), 64'h1234_5678, 1'b0, 0, 3'd0, "R1 off-region store");
    do_req(1'b0, mk_addr(3'd2, 3), 64'd0, 1'b0, 0, 3'd0, "R1 off-region load");
    pop(3, "R1 stack unchanged");
    // R2 out-of-range index
    push(NS + 3, 35'h99, "R2 store dropped");
    pop(NS + 3, "R2 out-of-range load");
    // R9 config + same-cycle pop reports old code
    do_req(1'b1, mk_addr(3'd6, 0), 64'h800, 1'b1, 0, 3'd5, "R9 cfg write");
    do_req(1'b0, mk_addr(3'd6, 0), 64'd0, 1'b1, 0, 3'd7, "R9 same-cycle old size");
    push(0, 35'h3ff, "R9 setup");
    pop(0, "R9 new size seen");
    // random mix
    for (int n = 0; n < 600; n++) begin
      bit wr; int idx; logic [2:0] reg_; logic [63:0] wd;
      wr   = ($urandom % 2) == 0;
      idx  = $urandom % (NS + 1);
      reg_ = (($urandom % 10) == 0) ? 3'($urandom % 6) : 3'd6;
      wd   = {$urandom, $urandom};
      do_req(wr, mk_addr(reg_, idx), wd, ($urandom % 4) == 0, $urandom % (NS + 1),
             3'($urandom), wr ? "R3 R7 random store" : "R4 R5 R6 R9 random load");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule